// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder/Decoder

This block connects a UART to an infrared transceiver for serial-infrared links. It runs on the system clock and advances only on the UART's 16x baud-rate tick. In transmit mode it watches the UART transmit line and turns every logic-0 bit into a short high pulse on the infrared transmit output. Logic-1 bits produce no pulse. In receive mode it synchronizes the infrared receive line and stretches every pulse it detects into one full low bit on the line that feeds the UART receiver.

The link is half-duplex. A single mode input selects encoding or decoding, and the path that is not selected is held at its idle level. Bit windows follow the UART's framing: the transmit counter realigns on each falling edge of the transmit line, so a window always begins at a bit boundary.

Top module: `sir_endec`

## Requirements
- R1: A transmit bit window is 16 baud ticks long. It restarts at tick position 0 on the first tick that sees the UART transmit line fall from 1 to 0. After that, each later window samples the line once, on the tick that ends the previous window.
- R2: For a bit window that carries logic 1, `ir_txd` stays 0 for all 16 ticks.
- R3: For a bit window that carries logic 0, `ir_txd` is 0 at tick positions 0 to 6, 1 at positions 7 to 9, and 0 at positions 10 to 15. This gives exactly 3 high ticks per zero bit.
- R4: While `rx_mode` is 1 the encoder is disabled and `ir_txd` is 0, whatever `uart_txd` does.
- R5: While `rx_mode` is 0 the decoder is disabled and `uart_rxd` is 1, whatever `ir_rxd` does.
- R6: When `rx_mode` is 1, `ir_rxd` passes through a two-flop synchronizer. A 0-to-1 change that is sampled at clock edge k makes `uart_rxd` go 0 after edge k+2. It then stays 0 for exactly 16 baud ticks and returns to 1. When no pulse is being decoded it rests at 1.
- R7: A rising edge on `ir_rxd` that arrives while a decoded low bit is in progress has no effect: the low bit neither restarts nor lengthens. A rising edge that arrives after the bit has ended starts a new 16-tick low bit.
- R8: While `rst_n` is 0, `ir_txd` is 0 and `uart_rxd` is 1, and all counters and synchronizer stages return to their cleared state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| uart_txd | input | 1 | Serial transmit line from the UART, idle high |
| ir_rxd | input | 1 | Pulse input from the infrared receiver, asynchronous |
| rx_mode | input | 1 | 1 selects decoding, 0 selects encoding |
| ir_txd | output | 1 | Pulse output to the infrared emitter |
| uart_rxd | output | 1 | Decoded serial level to the UART receiver, idle high |

## Verification
The hardest case to reach is the one in R7: a second infrared pulse arriving while a decoded low bit is still running. The stimulus sends two pulses about eight ticks apart and then checks that the low bit lasts exactly 16 ticks, not longer. A third pulse after the bit has ended then shows that a new low bit does start. The realignment in R1 is exercised by frames whose data holds 1-to-0 transitions in the middle of the frame. A behavioural model compares both outputs every cycle through mode switches and a reset applied partway through a decoded bit.

// File: rtl/sir_pkg.sv
package sir_pkg;
  // Baud ticks in one serial bit.
  parameter int TICKS_PER_BIT = 16;
  // Tick position at which the transmit pulse begins.
  parameter int PULSE_OFFSET  = 7;
  // Width of the transmit pulse, in ticks.
  parameter int PULSE_TICKS   = 3;
  // Flops in the receive synchronizer.
  parameter int SYNC_DEPTH    = 2;
  // Width of the tick position counters.
  parameter int CNT_W = $clog2(TICKS_PER_BIT);
endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [DEPTH-1:0] stage_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[DEPTH-1];
endmodule

// File: rtl/sir_tx_encoder.sv
module sir_tx_encoder #(
  parameter int TICKS  = 16,
  parameter int OFFSET = 7,
  parameter int WIDTH  = 3,
  parameter int CNT_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic txd,
  output logic pulse
);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(TICKS - 1);
  localparam logic [CNT_W-1:0] PULSE_LO  = CNT_W'(OFFSET);
  localparam logic [CNT_W-1:0] PULSE_HI  = CNT_W'(OFFSET + WIDTH - 1);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             bit_q, bit_d;
  logic             line_q, line_d;
  logic             fall_seen;

  assign fall_seen = line_q & ~txd;

  always_comb begin
    pos_d  = pos_q;
    bit_d  = bit_q;
    line_d = line_q;
    if (!enable) begin
      pos_d  = '0;
      bit_d  = 1'b1;
      line_d = 1'b1;
    end else if (tick) begin
      line_d = txd;
      if (fall_seen) begin
        pos_d = '0;
        bit_d = 1'b0;
      end else if (pos_q == LAST_POS) begin
        pos_d = '0;
        bit_d = txd;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      bit_q  <= 1'b1;
      line_q <= 1'b1;
    end else begin
      pos_q  <= pos_d;
      bit_q  <= bit_d;
      line_q <= line_d;
    end
  end

  assign pulse = enable & ~bit_q & (pos_q >= PULSE_LO) & (pos_q <= PULSE_HI);
endmodule

// File: rtl/sir_rx_decoder.sv
module sir_rx_decoder #(
  parameter int TICKS = 16,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic pulse_sync,
  output logic rxd
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] len_q, len_d;
  logic             busy_q, busy_d;
  logic             prev_q;
  logic             rise;

  assign rise = pulse_sync & ~prev_q;

  always_comb begin
    len_d  = len_q;
    busy_d = busy_q;
    if (!enable) begin
      len_d  = '0;
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        if (len_q == LAST_POS) begin
          len_d  = '0;
          busy_d = 1'b0;
        end else begin
          len_d = len_q + 1'b1;
        end
      end
    end else if (rise) begin
      len_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      busy_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      busy_q <= busy_d;
      prev_q <= pulse_sync;
    end
  end

  assign rxd = ~(busy_q & enable);
endmodule

// File: rtl/sir_endec.sv
module sir_endec
  import sir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic uart_txd,
  input  logic ir_rxd,
  input  logic rx_mode,
  output logic ir_txd,
  output logic uart_rxd
);
  logic rx_sync;

  sir_tx_encoder #(
    .TICKS (TICKS_PER_BIT),
    .OFFSET(PULSE_OFFSET),
    .WIDTH (PULSE_TICKS),
    .CNT_W (CNT_W)
  ) enc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .enable(~rx_mode),
    .txd   (uart_txd),
    .pulse (ir_txd)
  );

  sir_sync #(
    .DEPTH(SYNC_DEPTH)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ir_rxd),
    .sync_out(rx_sync)
  );

  sir_rx_decoder #(
    .TICKS(TICKS_PER_BIT),
    .CNT_W(CNT_W)
  ) dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .enable    (rx_mode),
    .pulse_sync(rx_sync),
    .rxd       (uart_rxd)
  );
endmodule

// File: rtl/sir_endec_checker.sv
module sir_endec_checker
  import sir_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic ir_rxd,
  input logic rx_mode,
  input logic ir_txd,
  input logic uart_rxd
);
  logic [4:0] hi_ticks_q;
  logic [5:0] lo_ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks_q <= '0;
      lo_ticks_q <= '0;
    end else begin
      if (!ir_txd)        hi_ticks_q <= '0;
      else if (baud_tick && hi_ticks_q != 5'h1f) hi_ticks_q <= hi_ticks_q + 1'b1;
      if (uart_rxd)       lo_ticks_q <= '0;
      else if (baud_tick && lo_ticks_q != 6'h3f) lo_ticks_q <= lo_ticks_q + 1'b1;
    end
  end

  assert_tx_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode |-> !ir_txd);

  assert_rx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |-> uart_rxd);

  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks_q <= 5'(PULSE_TICKS));

  assert_low_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ticks_q <= 6'(TICKS_PER_BIT));

  assert_low_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uart_rxd) |-> rx_mode && $past(ir_rxd, 3));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R8: assert (!ir_txd && uart_rxd);
    end
  end
endmodule

bind sir_endec sir_endec_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .ir_rxd   (ir_rxd),
  .rx_mode  (rx_mode),
  .ir_txd   (ir_txd),
  .uart_rxd (uart_rxd)
);

// File: tb/sir_endec_tb.sv
`timescale 1ns/1ps
module sir_endec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic uart_txd = 1'b1;
  logic ir_rxd = 1'b0;
  logic rx_mode = 1'b0;
  logic ir_txd, uart_rxd;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sir_endec dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .uart_txd(uart_txd),
    .ir_rxd(ir_rxd), .rx_mode(rx_mode), .ir_txd(ir_txd), .uart_rxd(uart_rxd)
  );

  // Baud tick: one cycle in four.
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div  = (tick_div + 1) % 4;
    baud_tick <= (tick_div == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int m_pos = 0, m_bit = 1, m_line = 1;
  int m_s1 = 0, m_s2 = 0, m_prev = 0, m_busy = 0, m_len = 0;
  always @(posedge clk) begin
    int rise;
    if (!rst_n) begin
      m_pos = 0; m_bit = 1; m_line = 1;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_busy = 0; m_len = 0;
    end else begin
      if (rx_mode) begin
        m_pos = 0; m_bit = 1; m_line = 1;
      end else if (baud_tick) begin
        if (m_line == 1 && uart_txd == 0) begin
          m_pos = 0; m_bit = 0;
        end else begin
          m_pos = (m_pos + 1) % 16;
          if (m_pos == 0) m_bit = uart_txd;
        end
        m_line = uart_txd;
      end
      rise = (m_s2 == 1 && m_prev == 0);
      if (!rx_mode) begin
        m_busy = 0; m_len = 0;
      end else if (m_busy == 1) begin
        if (baud_tick) begin
          if (m_len == 15) begin m_busy = 0; m_len = 0; end
          else m_len++;
        end
      end else if (rise) begin
        m_busy = 1; m_len = 0;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ir_rxd;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_tx, exp_rx;
      exp_tx = (!rx_mode && m_bit == 0 && m_pos >= 7 && m_pos <= 9) ? 1 : 0;
      exp_rx = (m_busy == 1 && rx_mode) ? 0 : 1;
      if (rx_mode) check(ir_txd == exp_tx, "R4 ir_txd", ir_txd, exp_tx);
      else         check(ir_txd == exp_tx, "R1 R2 R3 ir_txd", ir_txd, exp_tx);
      if (rx_mode) check(uart_rxd == exp_rx, "R6 R7 uart_rxd", uart_rxd, exp_rx);
      else         check(uart_rxd == exp_rx, "R5 uart_rxd", uart_rxd, exp_rx);
    end
  end

  // Event monitors for directed checks.
  int hi_ticks = 0, lo_ticks = 0, lo_cyc = 0;
  always @(posedge clk) begin
    if (baud_tick && ir_txd)    hi_ticks++;
    if (baud_tick && !uart_rxd) lo_ticks++;
    if (!uart_rxd)              lo_cyc++;
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baud_tick);
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] data);
    logic [9:0] frame;
    frame = {1'b1, data, 1'b0};
    wait_ticks(1);
    for (int b = 0; b < 10; b++) begin
      uart_txd = frame[b];
      wait_ticks(16);
    end
  endtask

  task automatic ir_pulse();
    ir_rxd = 1'b1;
    wait_ticks(3);
    ir_rxd = 1'b0;
  endtask

  int snap;

  initial begin
    rx_mode = 1'b0;
    repeat (5) @(negedge clk);
    check(ir_txd == 1'b0, "R8 reset ir_txd", ir_txd, 0);
    check(uart_rxd == 1'b1, "R8 reset uart_rxd", uart_rxd, 1);
    rst_n = 1'b1;
    wait_ticks(4);

    // R3: 0x55 carries start + four zero data bits = 5 zeros -> 15 high ticks.
    snap = hi_ticks; send_frame(8'h55);
    check(hi_ticks - snap == 15, "R3 pulses for 0x55", hi_ticks - snap, 15);
    // R2: 0xFF carries only the start zero -> 3 high ticks.
    snap = hi_ticks; send_frame(8'hFF);
    check(hi_ticks - snap == 3, "R2 pulses for 0xFF", hi_ticks - snap, 3);
    // R1: 0x00 nine zeros in a row, windows stay aligned -> 27.
    snap = hi_ticks; send_frame(8'h00);
    check(hi_ticks - snap == 27, "R1 pulses for 0x00", hi_ticks - snap, 27);
    // R1: mixed data with mid-frame falling edges, 0xA6 has 4 zeros + start.
    snap = hi_ticks; send_frame(8'hA6);
    check(hi_ticks - snap == 15, "R1 pulses for 0xA6", hi_ticks - snap, 15);

    // R5: a pulse in encode mode leaves uart_rxd high.
    snap = lo_cyc; ir_pulse(); wait_ticks(20);
    check(lo_cyc - snap == 0, "R5 decoder idle", lo_cyc - snap, 0);

    // R4: decode mode, transmit activity produces no pulse.
    rx_mode = 1'b1; wait_ticks(2);
    snap = hi_ticks; send_frame(8'h00);
    check(hi_ticks - snap == 0, "R4 encoder quiet", hi_ticks - snap, 0);

    // R6: one pulse gives a 16-tick low bit.
    snap = lo_ticks; ir_pulse(); wait_ticks(24);
    check(lo_ticks - snap == 16, "R6 low bit length", lo_ticks - snap, 16);

    // R7: second pulse inside the low bit is ignored.
    snap = lo_ticks; ir_pulse(); wait_ticks(5); ir_pulse(); wait_ticks(24);
    check(lo_ticks - snap == 16, "R7 overlapping pulse", lo_ticks - snap, 16);
    // R7: a pulse after the bit ended starts a new one.
    snap = lo_ticks; ir_pulse(); wait_ticks(24);
    check(lo_ticks - snap == 16, "R7 new bit after end", lo_ticks - snap, 16);

    // R8: reset in the middle of a decoded bit.
    ir_pulse(); wait_ticks(2);
    check(uart_rxd == 1'b0, "R6 low before reset", uart_rxd, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(uart_rxd == 1'b1, "R8 mid-bit reset uart_rxd", uart_rxd, 1);
    check(ir_txd == 1'b0, "R8 mid-bit reset ir_txd", ir_txd, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_ticks(20);
    check(uart_rxd == 1'b1, "R8 idle after reset", uart_rxd, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule